// File: doc/BRIEF.md
# Status Flag Manipulation Unit

This block executes the one-byte instructions whose only job is to move or alter processor status flags. An issue stage hands it an opcode byte together with a snapshot of the flags register and of the two accumulator bytes. The unit returns the values those registers should take next, plus a write strobe for each register. The write strobes tell the register file which results to commit. When an opcode is not one of the unit's own, it raises an unhandled indication and leaves every register untouched.

Operations enter on a valid/ready stream and leave on a second valid/ready stream through a single output register. An operation is taken on a rising clock edge when `op_valid` and `op_ready` are both high, and its result is offered in the next cycle. `op_ready` is high whenever the output register is empty or is being drained in the same cycle (`res_ready` high). While `res_valid` is high and `res_ready` is low, the result and all of its strobes stay frozen and no new operation is taken.

The flags word is `FLAG_W` bits wide. Carry sits at bit `CF_POS` (default 0), interrupt enable at `IF_POS` (default 9) and direction at `DF_POS` (default 10). The low flag byte holds, from bit 7 down: sign, zero, reserved, aux carry, reserved, parity, fixed-one, carry.

Top module: `flagctl_unit`

## Requirements
- R1: Opcode 0xF5 returns the flags with only the carry bit (bit 0) inverted, and asserts only the flags write strobe.
- R2: Opcodes 0xF8 and 0xF9 set carry (bit 0) to opcode bit 0 and leave the other flag bits unchanged; only the flags strobe is asserted.
- R3: Opcodes 0xFA and 0xFB set interrupt enable (bit 9) to opcode bit 0 and leave the other flag bits unchanged; only the flags strobe is asserted.
- R4: Opcodes 0xFC and 0xFD set direction (bit 10) to opcode bit 0 and leave the other flag bits unchanged; only the flags strobe is asserted.
- R5: Opcode 0x9E loads flag bits 7, 6, 4, 2 and 0 from the same bits of the accumulator high byte. It forces bit 1 to 1 and bits 3 and 5 to 0, keeps flag bits above 7 unchanged, and asserts only the flags strobe.
- R6: Opcode 0x9F returns the low eight flag bits unchanged as the next accumulator high byte and asserts only the high-byte strobe.
- R7: Opcode 0xD6 returns 0xFF as the next accumulator low byte when carry is 1 and 0x00 when it is 0. It asserts only the low-byte strobe, so no flag changes.
- R8: Any other opcode asserts the unhandled output, asserts no write strobe, and returns the flags and accumulator bytes exactly as supplied.
- R9: Every result has exactly one of the four outputs {flags strobe, high-byte strobe, low-byte strobe, unhandled} high. A register whose strobe is low is returned with its supplied value.
- R10: An accepted operation produces `res_valid` in the next cycle. `op_ready` equals `!res_valid || res_ready`. While `res_valid && !res_ready`, all result outputs stay stable.
- R11: After reset `res_valid` is 0 and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be taken this cycle |
| op_byte | input | 8 | Opcode byte |
| flags_in | input | FLAG_W | Current flags register |
| ah_in | input | 8 | Current accumulator high byte |
| al_in | input | 8 | Current accumulator low byte |
| res_valid | output | 1 | Result offered |
| res_ready | input | 1 | Consumer takes the result |
| flags_next | output | FLAG_W | Next flags value |
| flags_we | output | 1 | Commit flags_next |
| ah_next | output | 8 | Next accumulator high byte |
| ah_we | output | 1 | Commit ah_next |
| al_next | output | 8 | Next accumulator low byte |
| al_we | output | 1 | Commit al_next |
| unhandled | output | 1 | Opcode not executed by this unit |

## Verification
The hardest situation to reach from the ports is a result that is still stalled when the consumer frees the output and a new operation is accepted in the same edge. This must not lose or repeat a result. The stimulus holds `res_ready` low at random for stretches while `op_valid` stays active, so stalls, drains and back-to-back acceptances happen thousands of times. The reserved-bit forcing of the flag load is reached with directed high bytes of all ones and all zeros, along with random bytes.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

  localparam logic [7:0] OPC_CARRY_FLIP  = 8'hF5;
  localparam logic [7:0] OPC_CARRY_CLR   = 8'hF8;
  localparam logic [7:0] OPC_CARRY_SET   = 8'hF9;
  localparam logic [7:0] OPC_INT_CLR     = 8'hFA;
  localparam logic [7:0] OPC_INT_SET     = 8'hFB;
  localparam logic [7:0] OPC_DIR_CLR     = 8'hFC;
  localparam logic [7:0] OPC_DIR_SET     = 8'hFD;
  localparam logic [7:0] OPC_FLAGS_LOAD  = 8'h9E;
  localparam logic [7:0] OPC_FLAGS_STORE = 8'h9F;
  localparam logic [7:0] OPC_CARRY_FILL  = 8'hD6;

  // low flag byte: bits copied from the high byte, and bits forced to one
  localparam logic [7:0] LOW_COPY_MASK = 8'b1101_0101;
  localparam logic [7:0] LOW_ONE_MASK  = 8'b0000_0010;

  typedef enum logic [2:0] {
    K_NONE,
    K_CARRY_FLIP,
    K_CARRY_LOAD,
    K_INT_LOAD,
    K_DIR_LOAD,
    K_FLAGS_FROM_AH,
    K_AH_FROM_FLAGS,
    K_AL_FILL
  } op_kind_e;

endpackage

// File: rtl/fcu_decode.sv
module fcu_decode
  import fcu_pkg::*;
(
  input  logic [7:0] op_byte,
  output op_kind_e   kind,
  output logic       new_bit
);
  always_comb begin
    new_bit = op_byte[0];
    unique case (op_byte)
      OPC_CARRY_FLIP:                kind = K_CARRY_FLIP;
      OPC_CARRY_CLR, OPC_CARRY_SET:  kind = K_CARRY_LOAD;
      OPC_INT_CLR, OPC_INT_SET:      kind = K_INT_LOAD;
      OPC_DIR_CLR, OPC_DIR_SET:      kind = K_DIR_LOAD;
      OPC_FLAGS_LOAD:                kind = K_FLAGS_FROM_AH;
      OPC_FLAGS_STORE:               kind = K_AH_FROM_FLAGS;
      OPC_CARRY_FILL:                kind = K_AL_FILL;
      default:                       kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/fcu_update.sv
module fcu_update
  import fcu_pkg::*;
#(
  parameter int FLAG_W = 16,
  parameter int CF_POS = 0,
  parameter int IF_POS = 9,
  parameter int DF_POS = 10
) (
  input  op_kind_e          kind,
  input  logic              new_bit,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [7:0]        ah_in,
  input  logic [7:0]        al_in,
  output logic [FLAG_W-1:0] flags_out,
  output logic              flags_we,
  output logic [7:0]        ah_out,
  output logic              ah_we,
  output logic [7:0]        al_out,
  output logic              al_we,
  output logic              unhandled
);
  localparam int LOW_W = 8;

  logic [LOW_W-1:0] loaded_low;
  logic             carry;

  assign loaded_low = (ah_in & LOW_COPY_MASK) | LOW_ONE_MASK;
  assign carry      = flags_in[CF_POS];

  always_comb begin
    flags_out = flags_in;
    ah_out    = ah_in;
    al_out    = al_in;
    flags_we  = 1'b0;
    ah_we     = 1'b0;
    al_we     = 1'b0;
    unhandled = 1'b0;
    case (kind)
      K_CARRY_FLIP: begin
        flags_out[CF_POS] = ~carry;
        flags_we          = 1'b1;
      end
      K_CARRY_LOAD: begin
        flags_out[CF_POS] = new_bit;
        flags_we          = 1'b1;
      end
      K_INT_LOAD: begin
        flags_out[IF_POS] = new_bit;
        flags_we          = 1'b1;
      end
      K_DIR_LOAD: begin
        flags_out[DF_POS] = new_bit;
        flags_we          = 1'b1;
      end
      K_FLAGS_FROM_AH: begin
        flags_out[LOW_W-1:0] = loaded_low;
        flags_we             = 1'b1;
      end
      K_AH_FROM_FLAGS: begin
        ah_out = flags_in[LOW_W-1:0];
        ah_we  = 1'b1;
      end
      K_AL_FILL: begin
        al_out = {LOW_W{carry}};
        al_we  = 1'b1;
      end
      default: unhandled = 1'b1;
    endcase
  end
endmodule

// File: rtl/fcu_out_stage.sv
module fcu_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/flagctl_unit.sv
module flagctl_unit
  import fcu_pkg::*;
#(
  parameter int FLAG_W = 16,
  parameter int CF_POS = 0,
  parameter int IF_POS = 9,
  parameter int DF_POS = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [7:0]        op_byte,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [7:0]        ah_in,
  input  logic [7:0]        al_in,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [FLAG_W-1:0] flags_next,
  output logic              flags_we,
  output logic [7:0]        ah_next,
  output logic              ah_we,
  output logic [7:0]        al_next,
  output logic              al_we,
  output logic              unhandled
);
  localparam int PAY_W = FLAG_W + 16 + 4;

  op_kind_e          kind;
  logic              new_bit;
  logic [FLAG_W-1:0] u_flags;
  logic [7:0]        u_ah, u_al;
  logic              u_fwe, u_ahwe, u_alwe, u_unh;
  logic [PAY_W-1:0]  pay_in, pay_out;

  fcu_decode u_dec (
    .op_byte (op_byte),
    .kind    (kind),
    .new_bit (new_bit)
  );

  fcu_update #(
    .FLAG_W (FLAG_W),
    .CF_POS (CF_POS),
    .IF_POS (IF_POS),
    .DF_POS (DF_POS)
  ) u_upd (
    .kind      (kind),
    .new_bit   (new_bit),
    .flags_in  (flags_in),
    .ah_in     (ah_in),
    .al_in     (al_in),
    .flags_out (u_flags),
    .flags_we  (u_fwe),
    .ah_out    (u_ah),
    .ah_we     (u_ahwe),
    .al_out    (u_al),
    .al_we     (u_alwe),
    .unhandled (u_unh)
  );

  assign pay_in = {u_unh, u_alwe, u_ahwe, u_fwe, u_al, u_ah, u_flags};

  fcu_out_stage #(.W(PAY_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (op_valid),
    .in_ready  (op_ready),
    .in_data   (pay_in),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (pay_out)
  );

  assign {unhandled, al_we, ah_we, flags_we, al_next, ah_next, flags_next} = pay_out;
endmodule

// File: rtl/flagctl_unit_chk.sv
module flagctl_unit_chk #(
  parameter int FLAG_W = 16,
  parameter int CF_POS = 0,
  parameter int IF_POS = 9,
  parameter int DF_POS = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic              op_ready,
  input logic [7:0]        op_byte,
  input logic [FLAG_W-1:0] flags_in,
  input logic [7:0]        ah_in,
  input logic [7:0]        al_in,
  input logic              res_valid,
  input logic              res_ready,
  input logic [FLAG_W-1:0] flags_next,
  input logic              flags_we,
  input logic [7:0]        ah_next,
  input logic              ah_we,
  input logic [7:0]        al_next,
  input logic              al_we,
  input logic              unhandled
);
  logic [7:0]        cap_op;
  logic [FLAG_W-1:0] cap_flags;
  logic [7:0]        cap_ah, cap_al;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_op    <= '0;
      cap_flags <= '0;
      cap_ah    <= '0;
      cap_al    <= '0;
    end else if (op_valid && op_ready) begin
      cap_op    <= op_byte;
      cap_flags <= flags_in;
      cap_ah    <= ah_in;
      cap_al    <= al_in;
    end
  end

  a_r1_carry_flip: assert property (@(posedge clk) disable iff (rst)
    res_valid && cap_op == 8'hF5 |-> flags_we &&
      flags_next == (cap_flags ^ (FLAG_W'(1) << CF_POS)));

  a_r5_reserved_bits: assert property (@(posedge clk) disable iff (rst)
    res_valid && cap_op == 8'h9E |-> flags_next[1] && !flags_next[3] && !flags_next[5]);

  a_r6_store_low: assert property (@(posedge clk) disable iff (rst)
    res_valid && ah_we |-> ah_next == cap_flags[7:0] && flags_next == cap_flags);

  a_r7_fill: assert property (@(posedge clk) disable iff (rst)
    res_valid && al_we |-> al_next == {8{cap_flags[CF_POS]}} && !flags_we);

  a_r8_unhandled: assert property (@(posedge clk) disable iff (rst)
    res_valid && unhandled |-> flags_next == cap_flags && ah_next == cap_ah && al_next == cap_al);

  a_r9_one_outcome: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $onehot({unhandled, al_we, ah_we, flags_we}));

  a_r10_accept_to_result: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_ready |=> res_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(flags_next) && $stable(ah_next) &&
      $stable(al_next) && $stable({unhandled, al_we, ah_we, flags_we}));

  a_r11_reset_empty: assert property (@(posedge clk)
    rst |=> !res_valid);
endmodule

bind flagctl_unit flagctl_unit_chk #(
  .FLAG_W (FLAG_W),
  .CF_POS (CF_POS),
  .IF_POS (IF_POS),
  .DF_POS (DF_POS)
) u_chk (.*);

// File: tb/flagctl_unit_bench.sv
module flagctl_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, op_ready, res_valid, res_ready;
  logic [7:0]  op_byte, ah_in, al_in, ah_next, al_next;
  logic [15:0] flags_in, flags_next;
  logic        flags_we, ah_we, al_we, unhandled;

  always #4 clk = ~clk;

  flagctl_unit u_flagctl_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready), .op_byte(op_byte),
    .flags_in(flags_in), .ah_in(ah_in), .al_in(al_in), .res_valid(res_valid),
    .res_ready(res_ready), .flags_next(flags_next), .flags_we(flags_we), .ah_next(ah_next),
    .ah_we(ah_we), .al_next(al_next), .al_we(al_we), .unhandled(unhandled));

  typedef struct packed {
    logic [15:0] f;
    logic [7:0]  ah;
    logic [7:0]  al;
    logic        fwe, ahwe, alwe, unh;
  } res_t;

  int checks = 0, fails = 0;
  bit done = 0;
  res_t  pend_exp, stall_val;
  string pend_tag;
  bit    pend = 0, stall_prev = 0;

  function automatic res_t model(logic [7:0] op, logic [15:0] f, logic [7:0] ah, logic [7:0] al);
    res_t e;
    e = '{f: f, ah: ah, al: al, fwe: 1'b0, ahwe: 1'b0, alwe: 1'b0, unh: 1'b0};
    case (op)
      8'hF5: begin e.f[0] = ~f[0]; e.fwe = 1; end
      8'hF8, 8'hF9: begin e.f[0] = op[0]; e.fwe = 1; end
      8'hFA, 8'hFB: begin e.f[9] = op[0]; e.fwe = 1; end
      8'hFC, 8'hFD: begin e.f[10] = op[0]; e.fwe = 1; end
      8'h9E: begin
        e.f[7:0] = {ah[7], ah[6], 1'b0, ah[4], 1'b0, ah[2], 1'b1, ah[0]};
        e.fwe = 1;
      end
      8'h9F: begin e.ah = f[7:0]; e.ahwe = 1; end
      8'hD6: begin e.al = f[0] ? 8'hFF : 8'h00; e.alwe = 1; end
      default: e.unh = 1;
    endcase
    return e;
  endfunction

  function automatic string tag_of(logic [7:0] op);
    case (op)
      8'hF5: return "R1";
      8'hF8, 8'hF9: return "R2";
      8'hFA, 8'hFB: return "R3";
      8'hFC, 8'hFD: return "R4";
      8'h9E: return "R5";
      8'h9F: return "R6";
      8'hD6: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic res_t actual();
    return '{f: flags_next, ah: ah_next, al: al_next, fwe: flags_we, ahwe: ah_we,
             alwe: al_we, unh: unhandled};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, evaluate after settling, edge follows
  task automatic cycle(bit v, logic [7:0] op, logic [15:0] f, logic [7:0] ah,
                       logic [7:0] al, bit rr);
    res_t a;
    @(negedge clk);
    op_valid = v; op_byte = op; flags_in = f; ah_in = ah; al_in = al; res_ready = rr;
    #1;
    a = actual();
    check(op_ready == (!res_valid || res_ready), "R10 ready rule",
          64'(op_ready), 64'(!res_valid || res_ready));
    if (stall_prev) begin
      check(res_valid && a == stall_val, "R10 hold", 64'(a), 64'(stall_val));
    end
    if (res_valid) begin
      check(pend, "R10 unexpected result", 64'(res_valid), 64'(pend));
      check(a == pend_exp, pend_tag, 64'(a), 64'(pend_exp));
      check($onehot({a.unh, a.alwe, a.ahwe, a.fwe}), "R9 one outcome",
            64'({a.unh, a.alwe, a.ahwe, a.fwe}), 64'd1);
    end
    stall_prev = res_valid && !res_ready;
    stall_val  = a;
    if (res_valid && res_ready) pend = 0;
    if (v && op_ready) begin
      pend_exp = model(op, f, ah, al);
      pend_tag = tag_of(op);
      pend     = 1;
    end
  endtask

  localparam logic [7:0] OPS [10] = '{8'hF5, 8'hF8, 8'hF9, 8'hFA, 8'hFB,
                                      8'hFC, 8'hFD, 8'h9E, 8'h9F, 8'hD6};

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; op_valid = 0; op_byte = 0; flags_in = 0; ah_in = 0; al_in = 0; res_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check(!res_valid, "R11 reset valid", 64'(res_valid), 64'd0);
    check(op_ready, "R11 reset ready", 64'(op_ready), 64'd1);

    // directed: every opcode on all-ones and all-zeros context
    for (int i = 0; i < 10; i++) begin
      cycle(1, OPS[i], 16'hFFFF, 8'h5A, 8'hC3, 1);
      cycle(1, OPS[i], 16'h0000, 8'hA5, 8'h3C, 1);
    end
    // R5 reserved positions with extreme high bytes
    cycle(1, 8'h9E, 16'h0000, 8'hFF, 8'h00, 1);
    cycle(1, 8'h9E, 16'hFFFF, 8'h00, 8'h00, 1);
    // R8 unhandled neighbours
    cycle(1, 8'h90, 16'h1234, 8'h56, 8'h78, 1);
    cycle(1, 8'hF4, 16'hBEEF, 8'h01, 8'h02, 1);
    cycle(1, 8'hF6, 16'h0F0F, 8'h11, 8'h22, 1);
    // R10 stall with a waiting operation, then drain
    cycle(1, 8'hD6, 16'h0001, 8'h00, 8'h00, 0);
    cycle(1, 8'hF5, 16'h0000, 8'h00, 8'h00, 0);
    cycle(1, 8'hF5, 16'h0000, 8'h00, 8'h00, 0);
    cycle(1, 8'hF5, 16'h0000, 8'h00, 8'h00, 1);
    cycle(0, 8'h00, 16'h0000, 8'h00, 8'h00, 1);
    cycle(0, 8'h00, 16'h0000, 8'h00, 8'h00, 1);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] op;
      op = ($urandom % 10 < 7) ? OPS[$urandom % 10] : 8'($urandom);
      cycle(($urandom % 10) < 6, op, 16'($urandom), 8'($urandom), 8'($urandom),
            ($urandom % 10) < 7);
    end
    // drain
    repeat (3) cycle(0, 8'h00, 16'h0000, 8'h00, 8'h00, 1);
    check(!pend, "R10 result lost", 64'(pend), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule